// File: doc/BRIEF.md
# Two-Channel Harmonic-Tracking RF Clock and Revolution Tag Generator

This block turns a programmed revolution frequency into an RF clock-enable stream and a once-per-revolution tag. Each channel holds a phase accumulator, 32 bits wide by default, that runs from the shared reference clock. On every cycle the accumulator advances by the revolution frequency word multiplied by the active harmonic number. The carry out of the accumulator is the RF clock-enable. A divider counts those enables and raises a tag on the enable that closes each revolution. This gives a synchronism marker that a downstream system can use to line up its timing to the beam revolution.

The harmonic can come from either of two sources. In automatic mode the block picks the power of two that keeps the RF rate within one octave, between a quarter and a half of the reference rate. The default cap on that power of two is 2^14. In manual mode the harmonic is an integer taken from an input and limited to the range 1 to 16535. A harmonic change never takes effect in the middle of a revolution: the new value is loaded on the tag. Frequency word changes take effect at once.

Both channels use one reference clock and one reset. They also share a synchronous phase-clear input, which restarts both channels on the same edge so that they begin phase aligned.

Top module: `rfclk_tag_gen`

## Requirements
- R1: While reset is applied, and until the first clock-enable after reset, rf_ce_o and tag_o stay low. Reset makes the active harmonic 1, so the first clock-enable after reset also carries a tag.
- R2: On each clock edge the accumulator (ACC_W bits) adds frev × active harmonic, modulo 2^ACC_W. rf_ce_o is high for the one cycle that follows an edge at which this addition carried out of the top bit.
- R3: When auto_i is 1, the requested harmonic is 2^k. Here k = (ACC_W−2) − p, where p is the index of the highest set bit of frev, and k is limited to the range 0 to HARM_LOG_MAX. A frev of zero gives k = HARM_LOG_MAX.
- R4: When auto_i is 0, the requested harmonic is harm_i. A value of 0 is treated as 1, and any value above HARM_MAX is treated as HARM_MAX.
- R5: tag_o is a one-cycle pulse that coincides with the rf_ce_o pulse that completes a revolution. A revolution is made up of as many clock-enables as the active harmonic, counted from reset, from a phase clear or from the previous tag.
- R6: The active harmonic changes only at a tag, where it loads the requested value, or at a phase clear. A change on the inputs in the middle of a revolution leaves the length of that revolution unchanged.
- R7: A phase_clr_i high at an edge clears the accumulators and divider counters of both channels on that same edge. It also loads the requested harmonic into each channel. Both outputs of both channels are low in the following cycle.
- R8: The two channels are independent. After a phase clear with identical inputs, the two channels produce identical outputs on every cycle.
- R9: A new frev value changes the accumulator increment from the very next edge, while the active harmonic stays as it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock shared by both channels |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| phase_clr_i | input | 1 | Synchronous clear of both channels' phase and divider |
| auto_i | input | NCH | Per channel: 1 selects the automatic power-of-two harmonic, 0 selects harm_i |
| harm_i | input | NCH*HARM_W | Per channel manual harmonic; channel c uses bits [c*HARM_W +: HARM_W] |
| frev_i | input | NCH*ACC_W | Per channel revolution frequency word; channel c uses bits [c*ACC_W +: ACC_W] |
| rf_ce_o | output | NCH | Per channel RF clock-enable pulse |
| tag_o | output | NCH | Per channel revolution tag pulse |

## Verification
The assertions assume that phase_clr_i, auto_i, harm_i and frev_i are synchronous to clk and never change close to a rising edge. They also assume that these inputs carry defined values once reset is released. The bench therefore drives every input on the falling edge and starts each scenario from a phase clear, or from reset with defined inputs. The bench uses a narrow configuration: a 16-bit accumulator, a harmonic limit of 40 and an automatic cap of 2^5. With this configuration the automatic sweep can visit every highest-bit position of the frequency word, and the manual sweep can visit every value of the harmonic field, each within a few revolutions.

// File: rtl/rfclk_pkg.sv
`timescale 1ns/1ps
package rfclk_pkg;
  typedef enum logic {
    HMODE_MANUAL = 1'b0,
    HMODE_AUTO   = 1'b1
  } hmode_e;
endpackage

// File: rtl/rfclk_rst_sync.sv
`timescale 1ns/1ps
module rfclk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= {shift_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = shift_q[STAGES-1];
endmodule

// File: rtl/rfclk_harm_sel.sv
`timescale 1ns/1ps
module rfclk_harm_sel
  import rfclk_pkg::*;
#(
  parameter int ACC_W        = 32,
  parameter int HARM_W       = 15,
  parameter int HARM_MAX     = 16535,
  parameter int HARM_LOG_MAX = 14
) (
  input  logic [ACC_W-1:0]  frev_i,
  input  hmode_e            mode_i,
  input  logic [HARM_W-1:0] harm_i,
  output logic [HARM_W-1:0] harm_o
);
  logic [HARM_W-1:0] pow2_h;
  logic [HARM_W-1:0] man_h;
  int                shift_k;

  // Smallest shift that lifts the highest set bit to position ACC_W-2.
  always_comb begin
    shift_k = HARM_LOG_MAX;
    for (int i = HARM_LOG_MAX; i >= 0; i--) begin
      if ((frev_i >> (ACC_W - 2 - i)) != '0) shift_k = i;
    end
    pow2_h = HARM_W'(1) << shift_k;
  end

  always_comb begin
    if (harm_i == '0)                          man_h = HARM_W'(1);
    else if (harm_i > HARM_W'(HARM_MAX))       man_h = HARM_W'(HARM_MAX);
    else                                       man_h = harm_i;
  end

  assign harm_o = (mode_i == HMODE_AUTO) ? pow2_h : man_h;
endmodule

// File: rtl/rfclk_chan.sv
`timescale 1ns/1ps
module rfclk_chan #(
  parameter int ACC_W    = 32,
  parameter int HARM_W   = 15,
  parameter int HARM_MAX = 16535
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic [ACC_W-1:0]  frev_i,
  input  logic [HARM_W-1:0] harm_req_i,
  output logic              rf_ce_o,
  output logic              tag_o
);
  logic [ACC_W-1:0]  acc_q, acc_d;
  logic [HARM_W-1:0] cnt_q, cnt_d;
  logic [HARM_W-1:0] harm_q, harm_d;
  logic              ce_q, ce_d;
  logic              tag_q, tag_d;

  logic [ACC_W-1:0]  step;
  logic [ACC_W:0]    sum;
  logic              carry;
  logic              rev_end;

  assign step    = frev_i * ACC_W'(harm_q);
  assign sum     = {1'b0, acc_q} + {1'b0, step};
  assign carry   = sum[ACC_W];
  assign rev_end = carry && (cnt_q == harm_q - 1'b1);

  always_comb begin
    if (clr_i) begin
      acc_d  = '0;
      cnt_d  = '0;
      harm_d = harm_req_i;
      ce_d   = 1'b0;
      tag_d  = 1'b0;
    end else begin
      acc_d  = sum[ACC_W-1:0];
      ce_d   = carry;
      tag_d  = rev_end;
      harm_d = rev_end ? harm_req_i : harm_q;
      if (!carry)       cnt_d = cnt_q;
      else if (rev_end) cnt_d = '0;
      else              cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      cnt_q  <= '0;
      harm_q <= HARM_W'(1);
      ce_q   <= 1'b0;
      tag_q  <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      cnt_q  <= cnt_d;
      harm_q <= harm_d;
      ce_q   <= ce_d;
      tag_q  <= tag_d;
    end
  end

  assign rf_ce_o = ce_q;
  assign tag_o   = tag_q;

  // R7: a clear leaves both outputs quiet on the following cycle
  a_r7_clear_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (!rf_ce_o && !tag_o));

  // R6: the active harmonic moves only together with a tag or after a clear
  a_r6_harm_at_tag: assert property (@(posedge clk) disable iff (!rst_n)
    (harm_q != $past(harm_q)) |-> (tag_o || $past(clr_i)));

  // R5: a tag is always one of the clock-enable pulses
  a_r5_tag_on_ce: assert property (@(posedge clk) disable iff (!rst_n)
    tag_o |-> rf_ce_o);

  // R5: divider position stays inside the current revolution
  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < harm_q);

  // R4: active harmonic never leaves the legal range
  a_r4_harm_range: assert property (@(posedge clk) disable iff (!rst_n)
    (harm_q >= HARM_W'(1)) && (harm_q <= HARM_W'(HARM_MAX)));
endmodule

// File: rtl/rfclk_tag_gen.sv
`timescale 1ns/1ps
module rfclk_tag_gen
  import rfclk_pkg::*;
#(
  parameter int NCH          = 2,
  parameter int ACC_W        = 32,
  parameter int HARM_W       = 15,
  parameter int HARM_MAX     = 16535,
  parameter int HARM_LOG_MAX = 14
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    phase_clr_i,
  input  logic [NCH-1:0]          auto_i,
  input  logic [NCH*HARM_W-1:0]   harm_i,
  input  logic [NCH*ACC_W-1:0]    frev_i,
  output logic [NCH-1:0]          rf_ce_o,
  output logic [NCH-1:0]          tag_o
);
  logic rst_n_sync;

  rfclk_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [HARM_W-1:0] harm_req;
    hmode_e            mode;

    assign mode = auto_i[c] ? HMODE_AUTO : HMODE_MANUAL;

    rfclk_harm_sel #(
      .ACC_W        (ACC_W),
      .HARM_W       (HARM_W),
      .HARM_MAX     (HARM_MAX),
      .HARM_LOG_MAX (HARM_LOG_MAX)
    ) u_sel (
      .frev_i (frev_i[c*ACC_W +: ACC_W]),
      .mode_i (mode),
      .harm_i (harm_i[c*HARM_W +: HARM_W]),
      .harm_o (harm_req)
    );

    rfclk_chan #(
      .ACC_W    (ACC_W),
      .HARM_W   (HARM_W),
      .HARM_MAX (HARM_MAX)
    ) u_chan (
      .clk        (clk),
      .rst_n      (rst_n_sync),
      .clr_i      (phase_clr_i),
      .frev_i     (frev_i[c*ACC_W +: ACC_W]),
      .harm_req_i (harm_req),
      .rf_ce_o    (rf_ce_o[c]),
      .tag_o      (tag_o[c])
    );

    // R3: automatic selection always requests a single power of two
    a_r3_auto_pow2: assert property (@(posedge clk) disable iff (!rst_n_sync)
      auto_i[c] |-> ($countones(harm_req) == 1));
  end
endmodule

// File: tb/rfclk_tag_gen_test.sv
`timescale 1ns/1ps
module rfclk_tag_gen_test;
  localparam int NCH  = 2;
  localparam int W    = 16;
  localparam int HW   = 6;
  localparam int HMAX = 40;
  localparam int KM   = 5;
  localparam int LIM  = 6000;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 phase_clr;
  logic [NCH-1:0]       auto_r;
  logic [NCH*HW-1:0]    harm_r;
  logic [NCH*W-1:0]     frev_r;
  logic [NCH-1:0]       rf_ce_o;
  logic [NCH-1:0]       tag_o;

  int checks = 0;
  int errors = 0;
  int mism   = 0;
  int mark   = 0;

  always #5 clk = ~clk;

  rfclk_tag_gen #(
    .NCH(NCH), .ACC_W(W), .HARM_W(HW), .HARM_MAX(HMAX), .HARM_LOG_MAX(KM)
  ) uut (
    .clk(clk), .rst_n(rst_n), .phase_clr_i(phase_clr),
    .auto_i(auto_r), .harm_i(harm_r), .frev_i(frev_r),
    .rf_ce_o(rf_ce_o), .tag_o(tag_o)
  );

  function automatic int exp_h(bit a, int h, int f);
    int k;
    int p;
    if (a) begin
      if (f == 0) k = KM;
      else begin
        p = 0;
        for (int i = 0; i < W; i++) if (f[i]) p = i;
        k = (W - 2) - p;
        if (k < 0) k = 0;
        if (k > KM) k = KM;
      end
      return 1 << k;
    end
    if (h == 0) return 1;
    if (h > HMAX) return HMAX;
    return h;
  endfunction

  // Arithmetic model from the requirements, valid from the first phase clear
  longint m_acc [NCH];
  int     m_cnt [NCH];
  int     m_h   [NCH];
  bit     m_ce  [NCH];
  bit     m_tag [NCH];
  bit     m_valid;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_valid <= 1'b0;
    else begin
      if (phase_clr) m_valid <= 1'b1;
      for (int c = 0; c < NCH; c++) begin
        longint st;
        longint sm;
        bit     cy;
        bit     we;
        int     f;
        int     nh;
        f  = int'(frev_r[c*W +: W]);
        nh = exp_h(auto_r[c], int'(harm_r[c*HW +: HW]), f);
        st = (longint'(f) * m_h[c]) % (longint'(1) << W);
        sm = m_acc[c] + st;
        cy = (sm >= (longint'(1) << W));
        we = cy && (m_cnt[c] == m_h[c] - 1);
        if (phase_clr) begin
          m_acc[c] <= 0; m_cnt[c] <= 0; m_h[c] <= nh;
          m_ce[c]  <= 1'b0; m_tag[c] <= 1'b0;
        end else begin
          m_acc[c] <= sm % (longint'(1) << W);
          m_ce[c]  <= cy;
          m_tag[c] <= we;
          if (we) begin m_cnt[c] <= 0; m_h[c] <= nh; end
          else if (cy) m_cnt[c] <= m_cnt[c] + 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (m_valid) begin
      for (int c = 0; c < NCH; c++) begin
        if (rf_ce_o[c] !== m_ce[c] || tag_o[c] !== m_tag[c]) mism++;
      end
    end
  end

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic set_ch(int c, bit a, int h, int f);
    auto_r[c]          = a;
    harm_r[c*HW +: HW] = HW'(h);
    frev_r[c*W +: W]   = W'(f);
  endtask

  task automatic clr_pulse();
    phase_clr = 1'b1;
    tick();
    phase_clr = 1'b0;
  endtask

  task automatic model_mark();
    mark = mism;
  endtask

  task automatic model_check(string req);
    check(mism == mark, req, mism - mark, 0);
    mark = mism;
  endtask

  // Waits for a tag on channel c, then counts enables up to and including the next tag
  task automatic revolution(int c, output int n, output bit seen);
    int lim;
    lim  = 0;
    n    = 0;
    seen = 1'b0;
    do begin tick(); lim++; end while (!tag_o[c] && lim < LIM);
    do begin
      tick(); lim++;
      if (rf_ce_o[c]) n++;
    end while (!tag_o[c] && lim < 2*LIM);
    seen = tag_o[c];
  endtask

  initial begin
    #(10ns * 190000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int  n;
    bit  seen;
    int  lim;
    int  diffs;
    rst_n     = 1'b0;
    phase_clr = 1'b0;
    auto_r    = '0;
    harm_r    = '0;
    frev_r    = '0;
    set_ch(0, 1'b0, 5, 24576 / 5);
    set_ch(1, 1'b1, 0, 700);

    // R1: quiet outputs while reset is held
    for (int i = 0; i < 4; i++) begin
      tick();
      check(rf_ce_o == '0 && tag_o == '0, "R1 outputs low in reset",
            int'({rf_ce_o, tag_o}), 0);
    end
    rst_n = 1'b1;

    // R1: first enable after reset carries a tag (harmonic 1 after reset)
    lim = 0;
    do begin tick(); lim++; end while (!rf_ce_o[0] && lim < LIM);
    check(rf_ce_o[0] && tag_o[0], "R1 first enable tagged",
          int'(tag_o[0]), 1);
    // R6: requested harmonic 5 loaded at that tag
    revolution(0, n, seen);
    // first call skips the tag in progress, so measure the next full one too
    check(seen && n == 5, "R6 harmonic loaded at tag after reset", n, 5);

    // R7: clear quiets both channels on the next cycle
    tick();
    clr_pulse();
    check(rf_ce_o == '0 && tag_o == '0, "R7 clear quiets outputs",
          int'({rf_ce_o, tag_o}), 0);
    model_mark();

    // R2 and R9: increment follows a new frequency word from the next edge
    set_ch(0, 1'b0, 1, 0);
    set_ch(1, 1'b0, 3, 24576 / 3);
    clr_pulse();
    for (int i = 0; i < 5; i++) begin
      tick();
      check(!rf_ce_o[0], "R2 zero word gives no enable", int'(rf_ce_o[0]), 0);
    end
    set_ch(0, 1'b0, 1, 40000);
    tick();
    check(!rf_ce_o[0], "R9 first edge no carry", int'(rf_ce_o[0]), 0);
    tick();
    check(rf_ce_o[0] && tag_o[0], "R9 carry on second edge",
          int'({rf_ce_o[0], tag_o[0]}), 3);
    tick();
    check(!rf_ce_o[0], "R2 third edge no carry", int'(rf_ce_o[0]), 0);
    tick();
    check(rf_ce_o[0], "R2 fourth edge carry", int'(rf_ce_o[0]), 1);
    model_check("R2 accumulator stream vs model");

    // R3: automatic harmonic over every highest-bit position
    for (int p = -1; p < W; p++) begin
      int f;
      f = (p < 0) ? 0 : ((p == 0) ? 1 : ((1 << p) | (1 << (p - 1))));
      set_ch(0, 1'b1, 0, f);
      set_ch(1, 1'b0, (p + 3) % 50, 24576 / ((p + 3) % 50 + 1));
      for (int i = 0; i < 700; i++) tick();
      model_check("R3 auto sweep vs model");
      if (p >= 5) begin
        clr_pulse();
        revolution(0, n, seen);
        check(seen && n == exp_h(1'b1, 0, f), "R3 auto revolution length",
              n, exp_h(1'b1, 0, f));
      end
    end

    // R4: manual harmonic over the whole field, with 0 and the upper clamp
    for (int h = 0; h < (1 << HW); h++) begin
      int eh;
      eh = exp_h(1'b0, h, 0);
      set_ch(0, 1'b0, h, 24576 / eh);
      set_ch(1, 1'b1, 0, 300 + 37 * h);
      clr_pulse();
      revolution(0, n, seen);
      check(seen && n == eh, "R4 manual revolution length", n, eh);
    end
    model_check("R4 manual sweep vs model");

    // R5 and R6: a change mid-revolution only lands at the next tag
    set_ch(0, 1'b0, 4, 24576 / 4);
    clr_pulse();
    lim = 0;
    do begin tick(); lim++; end while (!tag_o[0] && lim < LIM);
    lim = 0;
    do begin tick(); lim++; end while (!rf_ce_o[0] && lim < LIM);
    set_ch(0, 1'b0, 7, 24576 / 4);
    n = 1;
    lim = 0;
    do begin
      tick(); lim++;
      if (rf_ce_o[0]) n++;
    end while (!tag_o[0] && lim < LIM);
    check(n == 4, "R6 current revolution keeps old harmonic", n, 4);
    n = 0;
    lim = 0;
    do begin
      tick(); lim++;
      if (rf_ce_o[0]) n++;
    end while (!tag_o[0] && lim < LIM);
    check(n == 7, "R5 next revolution uses new harmonic", n, 7);
    model_check("R5 tag stream vs model");

    // R8: identical inputs after a clear give identical outputs
    set_ch(0, 1'b1, 0, 900);
    set_ch(1, 1'b1, 0, 900);
    clr_pulse();
    diffs = 0;
    for (int i = 0; i < 900; i++) begin
      if (i == 300) begin set_ch(0, 1'b0, 9, 2700); set_ch(1, 1'b0, 9, 2700); end
      if (i == 600) begin set_ch(0, 1'b1, 0, 13000); set_ch(1, 1'b1, 0, 13000); end
      tick();
      if (rf_ce_o[0] !== rf_ce_o[1] || tag_o[0] !== tag_o[1]) diffs++;
    end
    check(diffs == 0, "R8 channels aligned after clear", diffs, 0);
    model_check("R8 channel streams vs model");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule